// File: doc/BRIEF.md
# Posted-Write Bus Bridge

This block connects a simple system-bus slave port to a peripheral-bus master port. It forwards reads and writes of 8, 16 or 32 bits. System-bus requests are held by the master until the bridge raises `sb_ready` for one cycle. The peripheral side uses a request/acknowledge handshake: `pb_req` and its address, data and strobe fields stay steady until `pb_ack`.

A write can be posted when all of the following hold:
- the permission input allows it;
- the requesting master has its buffering bit set;
- the addressed peripheral has its buffering bit set.

A posted write finishes on the system bus in the cycle it is presented. Its data waits in a small FIFO and is issued to the peripheral later. Any error the peripheral returns for it is dropped. Direct reads and writes wait for the peripheral and return its error flag. Every access reaches the peripheral in the order it was accepted. Requests with a bad size, a bad alignment or a failed permission check end at once with an error and never reach the peripheral.

Top module: `pwb_bridge`

## Requirements
- R1: A write that passes the permission check, has a legal size and alignment, and whose master bit (`mst_buf_en[sb_master]`) and peripheral bit (`per_buf_en[sb_addr[PSEL_LSB +: PSW]]`) are both 1 gets `sb_ready`=1 and `sb_err`=0 in the same cycle it is presented, provided the write buffer is not full.
- R2: A posted write is later issued on the peripheral side with the same address, data, size and strobes, and `pb_write`=1. An error returned by the peripheral for it never appears on `sb_err`.
- R3: Peripheral accesses occur in exactly the order the system bus accepted them, posted or not.
- R4: While the buffer holds DEPTH entries, a further postable write keeps `sb_ready`=0 until an entry leaves for the peripheral side.
- R5: A read, or a write that cannot be posted, is not issued while any earlier posted write is still buffered or in progress. Its `sb_ready` stays 0 until the buffer has drained.
- R6: A direct (non-posted) access completes with `sb_ready`=1 in the cycle `pb_ack` is 1. In that cycle `sb_err` equals `pb_err`, and for reads `sb_rdata` equals `pb_rdata`.
- R7: A request is rejected if any of the following hold:
  - size code 3 (64-bit);
  - a 16-bit access with `sb_addr[0]`=1;
  - a 32-bit access with `sb_addr[1:0]`≠0;
  - `sb_perm_ok`=0.

  A rejected request gets `sb_ready`=1 and `sb_err`=1 in the same cycle and never produces a peripheral access.
- R8: Size codes are 0 = 8-bit, 1 = 16-bit, 2 = 32-bit. `pb_strb` bit b is 1 exactly for the bytes b from `addr[1:0]` to `addr[1:0]` + 2^size − 1. `pb_size` repeats the size code.
- R9: During reset `sb_ready`=0 and `pb_req`=0.
- R10: `pb_req` and its address, data, size, strobe and direction stay stable until `pb_ack`. `pb_req` is 0 in the cycle after an acknowledge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sb_req | input | 1 | System-bus request, held until `sb_ready` |
| sb_write | input | 1 | 1 = write, 0 = read |
| sb_master | input | MIDW | Requesting master number |
| sb_addr | input | AW | Byte address |
| sb_size | input | 2 | Size code (0 = 8, 1 = 16, 2 = 32, 3 = 64 bits) |
| sb_wdata | input | 32 | Write data, lane-aligned |
| sb_perm_ok | input | 1 | Permission check result |
| mst_buf_en | input | 2^MIDW | Per-master posting enable |
| per_buf_en | input | 2^PSW | Per-peripheral posting enable |
| sb_ready | output | 1 | Request completes this cycle |
| sb_err | output | 1 | Completion carries an error |
| sb_rdata | output | 32 | Read data, valid with `sb_ready` on a read |
| pb_req | output | 1 | Peripheral request |
| pb_write | output | 1 | Peripheral direction |
| pb_addr | output | AW | Peripheral address |
| pb_size | output | 2 | Peripheral size code |
| pb_wdata | output | 32 | Peripheral write data |
| pb_strb | output | 4 | Byte lane strobes |
| pb_ack | input | 1 | Peripheral acknowledge |
| pb_err | input | 1 | Peripheral error, valid with `pb_ack` |
| pb_rdata | input | 32 | Peripheral read data, valid with `pb_ack` |

## Verification
A wrong FIFO count shows up on the first postable write after the buffer has filled: `sb_ready` comes one cycle early or late compared with the model's occupancy. A dropped or duplicated entry shows up at the very next acknowledge, as an address, data or strobe that does not match the expected order. A peripheral state machine that returns to idle at the wrong time shows up within one cycle in three ways:
- `pb_req` stays high after an acknowledge;
- a direct access is released too early;
- a read overtakes a posted write.

// File: rtl/pwb_pkg.sv
package pwb_pkg;

   typedef enum logic [1:0] {
      SZ_BYTE  = 2'd0,
      SZ_HALF  = 2'd1,
      SZ_WORD  = 2'd2,
      SZ_DWORD = 2'd3
   } pwb_size_e;

   typedef struct packed {
      logic        write;
      logic [31:0] data;
      logic [3:0]  strb;
      pwb_size_e   size;
   } pwb_beat_t;

   typedef enum logic {
      ENG_IDLE = 1'b0,
      ENG_BUSY = 1'b1
   } pwb_eng_e;

   // byte-lane mask for an access of the given size at a word offset
   function automatic logic [3:0] lane_mask(pwb_size_e sz, logic [1:0] off);
      logic [3:0] m;
      case (sz)
         SZ_BYTE: m = 4'(4'b0001 << off);
         SZ_HALF: m = 4'(4'b0011 << off);
         default: m = 4'b1111;
      endcase
      return m;
   endfunction

endpackage

// File: rtl/pwb_decode.sv
module pwb_decode
   import pwb_pkg::*;
#(
   parameter int AW       = 16,
   parameter int MIDW     = 2,
   parameter int PSW      = 2,
   parameter int PSEL_LSB = 12
)(
   input  logic                  write,
   input  logic [MIDW-1:0]       master,
   input  logic [AW-1:0]         addr,
   input  pwb_size_e             size,
   input  logic                  perm_ok,
   input  logic [(1<<MIDW)-1:0]  mst_buf_en,
   input  logic [(1<<PSW)-1:0]   per_buf_en,
   output logic                  reject,
   output logic                  bufferable,
   output logic [3:0]            strb
);

   logic             bad_size;
   logic             misaligned;
   logic             mst_ok;
   logic             per_ok;
   logic [PSW-1:0]   per_sel;

   always_comb begin
      bad_size   = (size == SZ_DWORD);
      misaligned = 1'b0;
      case (size)
         SZ_HALF: misaligned = addr[0];
         SZ_WORD: misaligned = |addr[1:0];
         default: misaligned = 1'b0;
      endcase
   end

   assign per_sel    = addr[PSEL_LSB +: PSW];
   assign mst_ok     = mst_buf_en[master];
   assign per_ok     = per_buf_en[per_sel];
   assign reject     = ~perm_ok | bad_size | misaligned;
   assign bufferable = write & ~reject & mst_ok & per_ok;
   assign strb       = lane_mask(size, addr[1:0]);

endmodule

// File: rtl/pwb_fifo.sv
module pwb_fifo #(
   parameter int W     = 8,
   parameter int DEPTH = 4
)(
   input  logic         clk,
   input  logic         rst_n,
   input  logic         push,
   input  logic [W-1:0] din,
   input  logic         pop,
   output logic [W-1:0] dout,
   output logic         empty,
   output logic         full
);

   localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
   localparam int CW = $clog2(DEPTH + 1);

   if (DEPTH < 1) begin : g_bad_depth
      $error("pwb_fifo: DEPTH must be at least 1");
   end

   if (DEPTH == 1) begin : g_single
      logic [W-1:0] hold_q;
      logic         vld_q;

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            hold_q <= '0;
            vld_q  <= 1'b0;
         end else begin
            if (push) hold_q <= din;
            vld_q <= push | (vld_q & ~pop);
         end
      end

      assign dout  = hold_q;
      assign empty = ~vld_q;
      assign full  = vld_q;
   end else begin : g_ring
      logic [W-1:0]  mem [DEPTH];
      logic [PW-1:0] wp_q;
      logic [PW-1:0] rp_q;
      logic [CW-1:0] cnt_q;

      always_ff @(posedge clk) begin
         if (push) mem[wp_q] <= din;
      end

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            wp_q  <= '0;
            rp_q  <= '0;
            cnt_q <= '0;
         end else begin
            if (push) wp_q <= (wp_q == PW'(DEPTH - 1)) ? '0 : wp_q + 1'b1;
            if (pop)  rp_q <= (rp_q == PW'(DEPTH - 1)) ? '0 : rp_q + 1'b1;
            cnt_q <= cnt_q + CW'(push) - CW'(pop);
         end
      end

      assign dout  = mem[rp_q];
      assign empty = (cnt_q == '0);
      assign full  = (cnt_q == CW'(DEPTH));

      AST_CNT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
         cnt_q <= CW'(DEPTH)); // R4
   end

   AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
      push |-> !full); // R4
   AST_NO_UNDERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
      pop |-> !empty); // R3

endmodule

// File: rtl/pwb_engine.sv
module pwb_engine
   import pwb_pkg::*;
#(
   parameter int AW = 16
)(
   input  logic          clk,
   input  logic          rst_n,
   input  logic          fifo_empty,
   input  logic [AW-1:0] fifo_addr,
   input  pwb_beat_t     fifo_beat,
   output logic          fifo_pop,
   input  logic          dir_go,
   input  logic [AW-1:0] dir_addr,
   input  pwb_beat_t     dir_beat,
   input  logic          pb_ack,
   output logic          pb_req,
   output logic [AW-1:0] pb_addr,
   output pwb_beat_t     pb_beat,
   output logic          src_dir,
   output logic          idle
);

   pwb_eng_e      state_q;
   logic [AW-1:0] addr_q;
   pwb_beat_t     beat_q;
   logic          dir_q;

   // buffered entries always win: anything direct has to wait for an empty FIFO
   assign fifo_pop = (state_q == ENG_IDLE) & ~fifo_empty;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q <= ENG_IDLE;
         addr_q  <= '0;
         beat_q  <= '0;
         dir_q   <= 1'b0;
      end else begin
         case (state_q)
            ENG_IDLE: begin
               if (fifo_pop) begin
                  addr_q  <= fifo_addr;
                  beat_q  <= fifo_beat;
                  dir_q   <= 1'b0;
                  state_q <= ENG_BUSY;
               end else if (dir_go) begin
                  addr_q  <= dir_addr;
                  beat_q  <= dir_beat;
                  dir_q   <= 1'b1;
                  state_q <= ENG_BUSY;
               end
            end
            ENG_BUSY: begin
               if (pb_ack) state_q <= ENG_IDLE;
            end
            default: state_q <= ENG_IDLE;
         endcase
      end
   end

   assign pb_req  = (state_q == ENG_BUSY);
   assign pb_addr = addr_q;
   assign pb_beat = beat_q;
   assign src_dir = dir_q;
   assign idle    = (state_q == ENG_IDLE);

   AST_REQ_HELD: assert property (@(posedge clk) disable iff (!rst_n)
      (pb_req && !pb_ack) |=> (pb_req && $stable(pb_addr) && $stable(pb_beat))); // R10
   AST_GAP_AFTER_ACK: assert property (@(posedge clk) disable iff (!rst_n)
      (pb_req && pb_ack) |=> !pb_req); // R10

endmodule

// File: rtl/pwb_bridge.sv
module pwb_bridge
   import pwb_pkg::*;
#(
   parameter int AW       = 16,
   parameter int MIDW     = 2,
   parameter int PSW      = 2,
   parameter int PSEL_LSB = 12,
   parameter int DEPTH    = 4,
   parameter bit BUF_EN   = 1'b1
)(
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic                  sb_req,
   input  logic                  sb_write,
   input  logic [MIDW-1:0]       sb_master,
   input  logic [AW-1:0]         sb_addr,
   input  logic [1:0]            sb_size,
   input  logic [31:0]           sb_wdata,
   input  logic                  sb_perm_ok,
   input  logic [(1<<MIDW)-1:0]  mst_buf_en,
   input  logic [(1<<PSW)-1:0]   per_buf_en,
   output logic                  sb_ready,
   output logic                  sb_err,
   output logic [31:0]           sb_rdata,
   output logic                  pb_req,
   output logic                  pb_write,
   output logic [AW-1:0]         pb_addr,
   output logic [1:0]            pb_size,
   output logic [31:0]           pb_wdata,
   output logic [3:0]            pb_strb,
   input  logic                  pb_ack,
   input  logic                  pb_err,
   input  logic [31:0]           pb_rdata
);

   localparam int BW = $bits(pwb_beat_t);
   localparam int FW = AW + BW;

   if (AW < 3) begin : g_bad_aw
      $error("pwb_bridge: AW must be at least 3");
   end
   if (PSEL_LSB + PSW > AW) begin : g_bad_psel
      $error("pwb_bridge: peripheral select field exceeds address width");
   end
   if (DEPTH < 1) begin : g_bad_depth
      $error("pwb_bridge: DEPTH must be at least 1");
   end

   logic          reject;
   logic          dec_buf;
   logic [3:0]    lane_strb;
   logic          buf_ok;
   logic          fifo_empty;
   logic          fifo_full;
   logic          fifo_pop;
   logic          fifo_push;
   logic [FW-1:0] fifo_dout;
   logic [AW-1:0] fifo_addr;
   pwb_beat_t     fifo_beat;
   pwb_beat_t     sb_beat;
   pwb_beat_t     eng_beat;
   logic          dir_go;
   logic          dir_done;
   logic          eng_src_dir;
   logic          eng_idle;
   logic          rej_now;

   pwb_decode #(
      .AW(AW), .MIDW(MIDW), .PSW(PSW), .PSEL_LSB(PSEL_LSB)
   ) i_decode (
      .write      (sb_write),
      .master     (sb_master),
      .addr       (sb_addr),
      .size       (pwb_size_e'(sb_size)),
      .perm_ok    (sb_perm_ok),
      .mst_buf_en (mst_buf_en),
      .per_buf_en (per_buf_en),
      .reject     (reject),
      .bufferable (dec_buf),
      .strb       (lane_strb)
   );

   always_comb begin
      sb_beat       = '0;
      sb_beat.write = sb_write;
      sb_beat.data  = sb_wdata;
      sb_beat.strb  = lane_strb;
      sb_beat.size  = pwb_size_e'(sb_size);
   end

   if (BUF_EN) begin : g_post
      assign buf_ok    = dec_buf;
      assign fifo_push = sb_req & buf_ok & ~fifo_full;

      pwb_fifo #(.W(FW), .DEPTH(DEPTH)) i_fifo (
         .clk   (clk),
         .rst_n (rst_n),
         .push  (fifo_push),
         .din   ({sb_addr, sb_beat}),
         .pop   (fifo_pop),
         .dout  (fifo_dout),
         .empty (fifo_empty),
         .full  (fifo_full)
      );
   end else begin : g_direct
      assign buf_ok     = 1'b0;
      assign fifo_push  = 1'b0;
      assign fifo_dout  = '0;
      assign fifo_empty = 1'b1;
      assign fifo_full  = 1'b1;
   end

   assign fifo_addr = fifo_dout[FW-1 -: AW];
   assign fifo_beat = pwb_beat_t'(fifo_dout[BW-1:0]);

   // a direct access may only start once nothing buffered is left ahead of it
   assign dir_go = sb_req & ~reject & ~buf_ok & fifo_empty & eng_idle;

   pwb_engine #(.AW(AW)) i_engine (
      .clk        (clk),
      .rst_n      (rst_n),
      .fifo_empty (fifo_empty),
      .fifo_addr  (fifo_addr),
      .fifo_beat  (fifo_beat),
      .fifo_pop   (fifo_pop),
      .dir_go     (dir_go),
      .dir_addr   (sb_addr),
      .dir_beat   (sb_beat),
      .pb_ack     (pb_ack),
      .pb_req     (pb_req),
      .pb_addr    (pb_addr),
      .pb_beat    (eng_beat),
      .src_dir    (eng_src_dir),
      .idle       (eng_idle)
   );

   assign dir_done = pb_req & eng_src_dir & pb_ack;
   assign rej_now  = sb_req & reject;
   assign sb_ready = rej_now | fifo_push | dir_done;
   assign sb_err   = rej_now | (dir_done & pb_err);
   assign sb_rdata = pb_rdata;

   assign pb_write = eng_beat.write;
   assign pb_size  = eng_beat.size;
   assign pb_wdata = eng_beat.data;
   assign pb_strb  = eng_beat.strb;

   AST_FULL_STALL: assert property (@(posedge clk) disable iff (!rst_n)
      (sb_req && buf_ok && fifo_full) |-> !sb_ready); // R4
   AST_READ_WAITS: assert property (@(posedge clk) disable iff (!rst_n)
      (sb_req && !sb_write && !fifo_empty) |-> (!sb_ready || sb_err)); // R5
   AST_POSTED_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
      (sb_req && buf_ok) |-> !sb_err); // R2
   AST_ERR_NEEDS_READY: assert property (@(posedge clk) disable iff (!rst_n)
      sb_err |-> sb_ready); // R7
   AST_DIR_ISSUE: assert property (@(posedge clk) disable iff (!rst_n)
      dir_go |=> (pb_req && pb_addr == $past(sb_addr))); // R6

endmodule

// File: tb/test_pwb_bridge.sv
module test_pwb_bridge;

   localparam int AW = 16;
   localparam int DEPTH = 4;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        sb_req = 1'b0;
   logic        sb_write = 1'b0;
   logic [1:0]  sb_master = '0;
   logic [AW-1:0] sb_addr = '0;
   logic [1:0]  sb_size = '0;
   logic [31:0] sb_wdata = '0;
   logic        sb_perm_ok = 1'b1;
   logic [3:0]  mst_buf_en = '0;
   logic [3:0]  per_buf_en = '0;
   logic        sb_ready, sb_err;
   logic [31:0] sb_rdata;
   logic        pb_req, pb_write;
   logic [AW-1:0] pb_addr;
   logic [1:0]  pb_size;
   logic [31:0] pb_wdata;
   logic [3:0]  pb_strb;
   logic        pb_ack = 1'b0;
   logic        pb_err = 1'b0;
   logic [31:0] pb_rdata = '0;

   always #2 clk = ~clk;

   pwb_bridge #(.AW(AW), .MIDW(2), .PSW(2), .PSEL_LSB(12), .DEPTH(DEPTH)) i_pwb_bridge (
      .clk(clk), .rst_n(rst_n), .sb_req(sb_req), .sb_write(sb_write), .sb_master(sb_master),
      .sb_addr(sb_addr), .sb_size(sb_size), .sb_wdata(sb_wdata), .sb_perm_ok(sb_perm_ok),
      .mst_buf_en(mst_buf_en), .per_buf_en(per_buf_en), .sb_ready(sb_ready), .sb_err(sb_err),
      .sb_rdata(sb_rdata), .pb_req(pb_req), .pb_write(pb_write), .pb_addr(pb_addr),
      .pb_size(pb_size), .pb_wdata(pb_wdata), .pb_strb(pb_strb), .pb_ack(pb_ack),
      .pb_err(pb_err), .pb_rdata(pb_rdata)
   );

   typedef struct {
      bit          wr;
      logic [1:0]  mid;
      logic [15:0] addr;
      logic [1:0]  size;
      logic [31:0] data;
      bit          perm;
   } stim_t;

   typedef struct {
      bit          wr;
      logic [15:0] addr;
      logic [31:0] data;
      logic [3:0]  strb;
      logic [1:0]  size;
      bit          posted;
   } exp_t;

   stim_t stim_q[$];
   exp_t  exp_q[$];
   stim_t cur;
   bit    busy = 0;
   bit    pushed = 0;
   int    wait_n = 2;
   int    hold = 0;
   int    total = 0;
   int    fails = 0;
   bit    done = 0;
   bit    last_req = 0, last_ack = 0, last_wr = 0;
   logic [15:0] last_addr = '0;
   logic [31:0] last_data = '0;
   logic [3:0]  last_strb = '0;

   task automatic chk(bit ok, string req, string what, logic [31:0] act, logic [31:0] exp);
      total++;
      if (!ok) begin
         fails++;
         $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
      end
   endtask

   function automatic logic [3:0] exp_strb(logic [1:0] size, logic [1:0] off);
      logic [3:0] m = '0;
      int nb = 1 << size;
      for (int b = 0; b < 4; b++)
         if (size == 2'd2 || (b >= off && b < off + nb)) m[b] = 1'b1;
      return m;
   endfunction

   task automatic summary();
      if (!done) begin
         done = 1;
         $display("  %0d/%0d checks passed", total - fails, total);
      end
   endtask

   task automatic add(bit wr, logic [1:0] mid, logic [15:0] addr, logic [1:0] size,
                      logic [31:0] data, bit perm = 1);
      stim_t s;
      s.wr = wr; s.mid = mid; s.addr = addr; s.size = size; s.data = data; s.perm = perm;
      stim_q.push_back(s);
   endtask

   task automatic step();
      bit rej, bufw, exp_rdy, exp_err, ack_pop;
      int occ;
      @(negedge clk);
      if (rst_n && !busy && stim_q.size() > 0) begin
         cur = stim_q.pop_front();
         busy = 1;
         pushed = 0;
      end
      sb_req = busy;
      sb_write = cur.wr; sb_master = cur.mid; sb_addr = cur.addr;
      sb_size = cur.size; sb_wdata = cur.data; sb_perm_ok = cur.perm;
      if (pb_req) hold++; else hold = 0;
      pb_ack   = pb_req && hold >= wait_n;
      pb_err   = pb_ack && pb_addr[4];
      pb_rdata = {pb_addr, ~pb_addr};
      #1;
      if (!rst_n) begin
         chk(sb_ready == 1'b0, "R9", "sb_ready in reset", 32'(sb_ready), 0);
         chk(pb_req == 1'b0, "R9", "pb_req in reset", 32'(pb_req), 0);
         return;
      end
      ack_pop = 0;
      if (pb_req && exp_q.size() == 0)
         chk(0, "R3", "peripheral access not expected", 32'(pb_addr), 0);
      if (last_ack)
         chk(pb_req == 1'b0, "R10", "pb_req after ack", 32'(pb_req), 0);
      if (last_req && !last_ack) begin
         chk(pb_req == 1'b1, "R10", "pb_req held", 32'(pb_req), 1);
         chk(pb_addr == last_addr && pb_wdata == last_data && pb_strb == last_strb
             && pb_write == last_wr, "R10", "pb fields stable", 32'(pb_addr), 32'(last_addr));
      end
      if (pb_req && pb_ack && exp_q.size() > 0) begin
         chk(pb_addr == exp_q[0].addr, "R3", "pb_addr order", 32'(pb_addr), 32'(exp_q[0].addr));
         chk(pb_write == exp_q[0].wr, "R2", "pb_write", 32'(pb_write), 32'(exp_q[0].wr));
         chk(pb_strb == exp_q[0].strb, "R8", "pb_strb", 32'(pb_strb), 32'(exp_q[0].strb));
         chk(pb_size == exp_q[0].size, "R8", "pb_size", 32'(pb_size), 32'(exp_q[0].size));
         if (exp_q[0].wr)
            chk(pb_wdata == exp_q[0].data, "R2", "pb_wdata", pb_wdata, exp_q[0].data);
         ack_pop = 1;
      end
      if (busy) begin
         rej  = (cur.size == 2'd3) || (cur.size == 2'd1 && cur.addr[0]) ||
                (cur.size == 2'd2 && cur.addr[1:0] != 2'b00) || !cur.perm;
         bufw = !rej && cur.wr && mst_buf_en[cur.mid] && per_buf_en[cur.addr[13:12]];
         if (rej) begin
            exp_rdy = 1; exp_err = 1;
            chk(sb_ready == exp_rdy && sb_err == exp_err, "R7", "reject response",
                32'({sb_ready, sb_err}), 32'b11);
         end else if (bufw) begin
            occ = exp_q.size() - (pb_req ? 1 : 0);
            exp_rdy = (occ < DEPTH); exp_err = 0;
            if (exp_rdy)
               chk(sb_ready == 1'b1 && sb_err == 1'b0, "R1", "posted write ready",
                   32'({sb_ready, sb_err}), 32'b10);
            else
               chk(sb_ready == 1'b0, "R4", "stall on full buffer", 32'(sb_ready), 0);
         end else begin
            if (!pushed) begin
               exp_t e;
               e.wr = cur.wr; e.addr = cur.addr; e.data = cur.data; e.size = cur.size;
               e.strb = exp_strb(cur.size, cur.addr[1:0]); e.posted = 0;
               exp_q.push_back(e);
               pushed = 1;
            end
            exp_rdy = pb_req && pb_ack && exp_q.size() == 1;
            exp_err = pb_err;
            if (exp_rdy) begin
               chk(sb_ready == 1'b1 && sb_err == exp_err, "R6", "direct completion",
                   32'({sb_ready, sb_err}), 32'({1'b1, exp_err}));
               if (!cur.wr)
                  chk(sb_rdata == {exp_q[0].addr, ~exp_q[0].addr}, "R6", "read data",
                      sb_rdata, {exp_q[0].addr, ~exp_q[0].addr});
            end else
               chk(sb_ready == 1'b0, "R5", "direct access waiting", 32'(sb_ready), 0);
         end
         if (bufw && exp_rdy) begin
            exp_t e;
            e.wr = 1; e.addr = cur.addr; e.data = cur.data; e.size = cur.size;
            e.strb = exp_strb(cur.size, cur.addr[1:0]); e.posted = 1;
            exp_q.push_back(e);
         end
         if (exp_rdy) busy = 0;
      end else
         chk(sb_ready == 1'b0, "R1", "no ready without request", 32'(sb_ready), 0);
      if (ack_pop) void'(exp_q.pop_front());
      last_req = pb_req; last_ack = pb_ack; last_wr = pb_write;
      last_addr = pb_addr; last_data = pb_wdata; last_strb = pb_strb;
   endtask

   task automatic drain();
      while (busy || stim_q.size() > 0 || exp_q.size() > 0) step();
      repeat (3) step();
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      $display("FAIL watchdog expired");
      fails++; total++;
      summary();
      $finish;
   end

   initial begin
      cur = '{wr: 0, mid: 0, addr: 0, size: 0, data: 0, perm: 1};
      repeat (3) step();
      rst_n = 1'b1;
      mst_buf_en = 4'b0011;
      per_buf_en = 4'b0101;

      // R1 R2 R3 R8: postable writes of mixed size, then a read behind them (R5 R6)
      wait_n = 2;
      add(1, 0, 16'h0004, 2, 32'h1111_2222);
      add(1, 1, 16'h0009, 0, 32'h0000_3300);
      add(1, 0, 16'h000E, 1, 32'h4455_0000);
      add(1, 1, 16'h2020, 2, 32'hCAFE_F00D);
      add(0, 0, 16'h0024, 2, 32'h0);
      drain();

      // R4: more postable writes than the buffer holds, slow peripheral
      wait_n = 6;
      for (int i = 0; i < 7; i++) add(1, 0, 16'(16'h0100 + 4 * i), 2, 32'(32'hA000 + i));
      add(0, 1, 16'h0108, 1, 32'h0);
      drain();

      // R2 dropped posted error, R6 direct errors and data
      wait_n = 3;
      add(1, 0, 16'h0010, 2, 32'hDEAD_0001);
      add(1, 2, 16'h0014, 2, 32'hBEEF_0002);
      add(1, 0, 16'h1000, 2, 32'h0000_0003);
      add(0, 0, 16'h1012, 1, 32'h0);
      add(0, 3, 16'h2003, 0, 32'h0);
      drain();

      // R7: rejects, some while the buffer is busy
      wait_n = 4;
      add(1, 0, 16'h0200, 2, 32'h5555_AAAA);
      add(1, 0, 16'h0208, 3, 32'h1);
      add(0, 0, 16'h0201, 1, 32'h0);
      add(1, 1, 16'h0202, 2, 32'h2);
      add(1, 0, 16'h0204, 2, 32'h3, 0);
      add(1, 0, 16'h0206, 1, 32'h7777_0000);
      drain();

      // no posting anywhere: strict direct sequence, back-to-back (R5 R6 R10)
      per_buf_en = 4'b0000;
      wait_n = 2;
      add(1, 0, 16'h0300, 0, 32'h0000_00AB);
      add(1, 1, 16'h0313, 0, 32'hCD00_0000);
      add(0, 0, 16'h0318, 2, 32'h0);
      drain();

      // posted writes with a non-posted write right behind them (R3 R5)
      per_buf_en = 4'b0001;
      wait_n = 3;
      add(1, 0, 16'h0400, 2, 32'h0101_0101);
      add(1, 0, 16'h0404, 2, 32'h0202_0202);
      add(1, 3, 16'h0408, 2, 32'h0303_0303);
      add(1, 0, 16'h040C, 2, 32'h0404_0404);
      drain();

      summary();
      $finish;
   end

endmodule